// File: doc/BRIEF.md
# Mute Pin and Clock Supervisor

This block watches the clocks and the audio sample stream that feed a multichannel DAC datapath and decides when the external, active-low mute pin must be pulled low. It counts master-clock (MCLK) cycles in every frame-clock (LRCK) period. When two successive periods differ by more than a fixed tolerance, it pulses a resynchronisation request into the datapath and raises a clock-error status bit. A free-running reference clock times how long MCLK has been silent. After a configurable timeout the block reports the clock error and asks the system to enter standby.

It also counts consecutive samples that are zero on all six DAC channels. When auto-mute is enabled and the run is long enough, the mute pin drops. A single non-zero sample on any channel lifts the auto-mute again. A forced-mute control bit, a power-down control and reset also hold the pin low. Any clock fault does the same.

The mute pin, the clock-error bit and the standby request are registered in the reference domain. The resync pulse, the sample inputs and the auto-mute enable belong to the MCLK domain.

Top module: `mute_clk_supervisor`

## Requirements
- R1: With `auto_mute_en` high, 512 consecutive valid samples with all six channels equal to zero drive `mute_n` low; after 511 such samples `mute_n` is still high.
- R2: A valid sample with any bit set on any one of the six channels (channel c occupies `smp_data[c*24 +: 24]`) clears the zero-run count at once, and `mute_n` returns high within a few reference cycles when nothing else mutes.
- R3: While `auto_mute_en` is low the zero-run count stays at zero and no auto-mute occurs. After re-enabling, a full fresh run of 512 zero samples is needed.
- R4: The zero-run count saturates at 512 and never wraps.
- R5: `force_mute` high drives `mute_n` low on the next reference clock edge.
- R6: `mute_n` is low and `clk_err` is high during reset; `power_down` high drives `mute_n` low on the next reference edge.
- R7: When the MCLK count of one LRCK period (rising edge to rising edge) differs from the previous period by more than 32, `resync` pulses high for one MCLK cycle. A difference of exactly 32 gives no pulse.
- R8: `clk_err` rises on a drift and stays high until two consecutive period comparisons are both within 32. The same two clean comparisons are needed after reset.
- R9: When MCLK stops for 2000 reference cycles (the default `STOP_TICKS`), `standby_req` and `clk_err` go high. Both clear shortly after MCLK resumes.
- R10: `mute_n` is low in every cycle in which `clk_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; times the MCLK-stop window and clocks the outputs |
| mclk | input | 1 | Master audio clock being supervised |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| lrck | input | 1 | Frame clock, synchronous to `mclk` |
| smp_valid | input | 1 | One-cycle strobe (MCLK domain) marking a new sample set |
| smp_data | input | 144 | Six 24-bit channel samples, channel c at bits c*24 upward |
| auto_mute_en | input | 1 | Enables zero-run auto-mute (MCLK domain) |
| force_mute | input | 1 | Forces the mute pin low (reference domain) |
| power_down | input | 1 | Power-down state; holds the mute pin low (reference domain) |
| mute_n | output | 1 | Active-low external mute pin |
| clk_err | output | 1 | Clock-error status: MCLK missing or ratio change not yet settled |
| standby_req | output | 1 | Standby request while MCLK is stopped |
| resync | output | 1 | One-cycle datapath resynchronisation pulse (MCLK domain) |

## Verification
On every cycle, the assertions check how mute reacts to the force and power-down controls and to a clock error. They also check that standby implies a clock error and that a resync is always one cycle wide and always comes with the internal ratio error. They watch the zero-run counter too: it stays within its limit, is cleared by a non-zero sample, and is held at zero while auto-mute is disabled. Other behaviours only show up in the bench's scenarios. These are the exact 511/512 threshold, release through each of the six channels, the 32-versus-33 cycle drift boundary, the two-comparison hold of the clock error, and the MCLK-stop timeout with recovery.

// File: rtl/mcs_pkg.sv
// Shared types for the mute and clock supervisor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mcs_pkg;

    // Progress of the frame-period tracker after reset.
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,   // no LRCK rising edge seen yet
        LK_FIRST = 2'd1,   // one edge seen, first period being counted
        LK_TRACK = 2'd2    // a previous period exists, comparisons active
    } lock_e;

endpackage

// File: rtl/mcs_sync2.sv
// Two-flop single-bit synchronizer with a selectable reset value.
// Assumes d is a level that stays stable for several destination cycles.
module mcs_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q;
    logic s2_q;

    // Shift the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/mcs_ratio_mon.sv
// Counts MCLK cycles between LRCK rising edges and compares each period
// with the one before. A difference above DRIFT_TOL gives a one-cycle
// resync pulse and sets the ratio error; the error clears after two
// consecutive comparisons within tolerance.
// Assumes lrck is synchronous to clk and rst_n is held for a few cycles.
module mcs_ratio_mon
    import mcs_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int DRIFT_TOL = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    output logic resync_o,
    output logic ratio_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] TOL     = CNT_W'(DRIFT_TOL);

    logic             lrck_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prev_q;
    logic [1:0]       ok_q;
    lock_e            state_q;
    logic             rise;
    logic [CNT_W-1:0] diff;
    logic             drift;

    assign rise  = lrck & ~lrck_q;
    assign diff  = (cnt_q >= prev_q) ? (cnt_q - prev_q) : (prev_q - cnt_q);
    assign drift = (diff > TOL);

    // Edge detect and saturating period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            lrck_q <= lrck;
            if (rise)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Period comparison, resync pulse and error hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LK_IDLE;
            prev_q      <= '0;
            ok_q        <= 2'd0;
            resync_o    <= 1'b0;
            ratio_err_o <= 1'b1;
        end else begin
            resync_o <= 1'b0;
            if (rise) begin
                case (state_q)
                    LK_IDLE:  state_q <= LK_FIRST;
                    LK_FIRST: begin
                        prev_q  <= cnt_q;
                        state_q <= LK_TRACK;
                    end
                    default: begin
                        prev_q <= cnt_q;
                        if (drift) begin
                            resync_o    <= 1'b1;
                            ratio_err_o <= 1'b1;
                            ok_q        <= 2'd0;
                        end else begin
                            if (ok_q != 2'd2) ok_q <= ok_q + 2'd1;
                            if (ok_q == 2'd1) ratio_err_o <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mcs_zero_det.sv
// Counts consecutive valid samples that are zero on every channel.
// The count saturates at ZERO_RUN and is held at zero while disabled.
// Assumes smp_valid is a single-cycle strobe in the clk domain.
module mcs_zero_det #(
    parameter int CH_N     = 6,
    parameter int SMP_W    = 24,
    parameter int ZERO_RUN = 512,
    localparam int ZRUN_W  = $clog2(ZERO_RUN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    smp_valid,
    input  logic [CH_N*SMP_W-1:0]   smp_data,
    output logic [ZRUN_W-1:0]       run_o,
    output logic                    auto_mute_o
);
    localparam logic [ZRUN_W-1:0] LIM = ZRUN_W'(ZERO_RUN);

    logic [CH_N-1:0] ch_nz;

    // One non-zero flag per channel.
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign ch_nz[c] = |smp_data[c*SMP_W +: SMP_W];
    end

    // Saturating zero-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_o <= '0;
        end else if (smp_valid) begin
            if (|ch_nz)
                run_o <= '0;
            else if (run_o != LIM)
                run_o <= run_o + ZRUN_W'(1);
        end
    end

    assign auto_mute_o = (run_o == LIM);
endmodule

// File: rtl/mcs_clk_watch.sv
// Detects a stopped MCLK. A request bit toggles in the MCLK domain each
// time the previous toggle has been acknowledged by the reference domain.
// The reference domain counts cycles without a new toggle; reaching
// STOP_TICKS flags the clock as stopped.
// Assumes ref_clk is free-running and rst_n is seen by both domains.
module mcs_clk_watch #(
    parameter int STOP_TICKS = 2000
) (
    input  logic mclk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic stopped_o
);
    localparam int IDLE_W = $clog2(STOP_TICKS + 1);
    localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(STOP_TICKS);

    logic              req_q;
    logic              ack_q;
    logic              ack_m;
    logic              req_r;
    logic [IDLE_W-1:0] idle_q;

    mcs_sync2 #(.RST_VAL(1'b0)) u_ack_sync (
        .clk(mclk), .rst_n(rst_n), .d(ack_q), .q(ack_m)
    );

    mcs_sync2 #(.RST_VAL(1'b0)) u_req_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(req_q), .q(req_r)
    );

    // MCLK side: issue the next toggle once the last one is acknowledged.
    always_ff @(posedge mclk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (ack_m == req_q)
            req_q <= ~req_q;
    end

    // Reference side: acknowledge toggles and time the silence between them.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            idle_q <= '0;
        end else begin
            ack_q <= req_r;
            if (req_r != ack_q)
                idle_q <= '0;
            else if (idle_q != IDLE_LIM)
                idle_q <= idle_q + IDLE_W'(1);
        end
    end

    assign stopped_o = (idle_q == IDLE_LIM);
endmodule

// File: rtl/mute_clk_supervisor.sv
// Top of the mute and clock supervisor. Combines zero-run auto-mute,
// forced mute, power-down and clock faults into the active-low mute pin,
// and reports clock error, standby request and datapath resync.
// Assumes: lrck, smp_*, auto_mute_en are in the mclk domain; force_mute and
// power_down are in the ref_clk domain; rst_n is held low for several
// cycles of both clocks with mclk running.
module mute_clk_supervisor #(
    parameter int CH_N       = 6,
    parameter int SMP_W      = 24,
    parameter int ZERO_RUN   = 512,
    parameter int DRIFT_TOL  = 32,
    parameter int CNT_W      = 12,
    parameter int STOP_TICKS = 2000
) (
    input  logic                  ref_clk,
    input  logic                  mclk,
    input  logic                  rst_n,
    input  logic                  lrck,
    input  logic                  smp_valid,
    input  logic [CH_N*SMP_W-1:0] smp_data,
    input  logic                  auto_mute_en,
    input  logic                  force_mute,
    input  logic                  power_down,
    output logic                  mute_n,
    output logic                  clk_err,
    output logic                  standby_req,
    output logic                  resync
);
    localparam int ZRUN_W = $clog2(ZERO_RUN + 1);

    logic              ratio_err_m;
    logic              ratio_err_r;
    logic              auto_mute_m;
    logic              auto_mute_r;
    logic              stopped;
    logic              clk_err_c;
    logic [ZRUN_W-1:0] zero_run;

    mcs_ratio_mon #(.CNT_W(CNT_W), .DRIFT_TOL(DRIFT_TOL)) u_ratio (
        .clk(mclk), .rst_n(rst_n), .lrck(lrck),
        .resync_o(resync), .ratio_err_o(ratio_err_m)
    );

    mcs_zero_det #(.CH_N(CH_N), .SMP_W(SMP_W), .ZERO_RUN(ZERO_RUN)) u_zero (
        .clk(mclk), .rst_n(rst_n), .en(auto_mute_en),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .run_o(zero_run), .auto_mute_o(auto_mute_m)
    );

    mcs_clk_watch #(.STOP_TICKS(STOP_TICKS)) u_watch (
        .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .stopped_o(stopped)
    );

    mcs_sync2 #(.RST_VAL(1'b1)) u_err_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(ratio_err_m), .q(ratio_err_r)
    );

    mcs_sync2 #(.RST_VAL(1'b0)) u_am_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(auto_mute_m), .q(auto_mute_r)
    );

    assign clk_err_c = stopped | ratio_err_r;

    // Register the pin and status outputs in the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            mute_n      <= 1'b0;
            clk_err     <= 1'b1;
            standby_req <= 1'b0;
        end else begin
            mute_n      <= ~(force_mute | power_down | clk_err_c | auto_mute_r);
            clk_err     <= clk_err_c;
            standby_req <= stopped;
        end
    end
endmodule

// File: rtl/mute_clk_supervisor_chk.sv
// Property checker for mute_clk_supervisor, attached by bind below.
// Assumes the same clock-domain split as the top module.
module mute_clk_supervisor_chk #(
    parameter int CH_N     = 6,
    parameter int SMP_W    = 24,
    parameter int ZERO_RUN = 512,
    localparam int ZRUN_W  = $clog2(ZERO_RUN + 1)
) (
    input logic                  ref_clk,
    input logic                  mclk,
    input logic                  rst_n,
    input logic                  force_mute,
    input logic                  power_down,
    input logic                  mute_n,
    input logic                  clk_err,
    input logic                  standby_req,
    input logic                  resync,
    input logic                  ratio_err_m,
    input logic                  auto_mute_en,
    input logic                  smp_valid,
    input logic [CH_N*SMP_W-1:0] smp_data,
    input logic [ZRUN_W-1:0]     zero_run
);
    a_r5_force_mutes: assert property (@(posedge ref_clk) disable iff (!rst_n)
        force_mute |=> !mute_n);

    a_r6_pdn_mutes: assert property (@(posedge ref_clk) disable iff (!rst_n)
        power_down |=> !mute_n);

    a_r10_err_mutes: assert property (@(posedge ref_clk) disable iff (!rst_n)
        clk_err |-> !mute_n);

    a_r9_standby_err: assert property (@(posedge ref_clk) disable iff (!rst_n)
        standby_req |-> clk_err);

    a_r7_resync_single: assert property (@(posedge mclk) disable iff (!rst_n)
        resync |=> !resync);

    a_r8_resync_sets_err: assert property (@(posedge mclk) disable iff (!rst_n)
        resync |-> ratio_err_m);

    a_r4_run_bounded: assert property (@(posedge mclk) disable iff (!rst_n)
        zero_run <= ZRUN_W'(ZERO_RUN));

    a_r3_disabled_clear: assert property (@(posedge mclk) disable iff (!rst_n)
        !auto_mute_en |=> (zero_run == '0));

    a_r2_nonzero_clear: assert property (@(posedge mclk) disable iff (!rst_n)
        (auto_mute_en && smp_valid && (|smp_data)) |=> (zero_run == '0));
endmodule

bind mute_clk_supervisor mute_clk_supervisor_chk #(
    .CH_N(CH_N), .SMP_W(SMP_W), .ZERO_RUN(ZERO_RUN)
) u_chk (
    .ref_clk(ref_clk), .mclk(mclk), .rst_n(rst_n),
    .force_mute(force_mute), .power_down(power_down),
    .mute_n(mute_n), .clk_err(clk_err), .standby_req(standby_req),
    .resync(resync), .ratio_err_m(ratio_err_m),
    .auto_mute_en(auto_mute_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .zero_run(zero_run)
);

// File: tb/sim_mute_clk_supervisor.sv
`timescale 1ns/100ps
module sim_mute_clk_supervisor;
    localparam int CH_N  = 6;
    localparam int SMP_W = 24;
    localparam int DW    = CH_N * SMP_W;

    logic          ref_clk = 1'b0;
    logic          mclk    = 1'b0;
    logic          mclk_run = 1'b1;
    logic          rst_n = 1'b0;
    logic          lrck = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          auto_mute_en = 1'b1;
    logic          force_mute = 1'b0;
    logic          power_down = 1'b0;
    logic          mute_n, clk_err, standby_req, resync;

    int n_chk  = 0;
    int n_fail = 0;
    int rs_cnt = 0;
    int per = 64;
    int next_per = 64;
    int pos = 0;
    bit done = 1'b0;
    event frame_ev;

    mute_clk_supervisor u0 (
        .ref_clk(ref_clk), .mclk(mclk), .rst_n(rst_n), .lrck(lrck),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .auto_mute_en(auto_mute_en), .force_mute(force_mute),
        .power_down(power_down), .mute_n(mute_n), .clk_err(clk_err),
        .standby_req(standby_req), .resync(resync)
    );

    // 200 MHz reference clock; MCLK with a 6.6 ns period that can be stopped.
    always #2.5 ref_clk = ~ref_clk;
    always begin
        #3.3;
        if (mclk_run) mclk = ~mclk;
    end

    // Frame clock generator: period latched at each frame start.
    always @(negedge mclk) begin
        if (pos == 0) begin
            per  = next_per;
            lrck = 1'b1;
            -> frame_ev;
        end
        if (pos == per / 2) lrck = 1'b0;
        pos = pos + 1;
        if (pos >= per) pos = 0;
    end

    // Count resync pulses away from the active edge.
    always @(negedge mclk) if (resync) rs_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic wait_frames(input int n);
        repeat (n) @(frame_ev);
    endtask

    task automatic send(input logic [DW-1:0] d);
        @(negedge mclk);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge mclk);
        smp_valid = 1'b0;
        smp_data  = '0;
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send('0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        wait_ref(20);
        // R6: reset state
        check(mute_n == 1'b0, "R6", "mute_n in reset", int'(mute_n), 0);
        check(clk_err == 1'b1, "R6", "clk_err in reset", int'(clk_err), 1);
        rst_n = 1'b1;
        send(DW'(1));
        wait_ref(600);
        // R8: lock after two clean comparisons
        check(clk_err == 1'b0, "R8", "clk_err after lock", int'(clk_err), 0);
        check(mute_n == 1'b1, "R10", "mute_n after lock", int'(mute_n), 1);
        check(standby_req == 1'b0, "R9", "standby idle", int'(standby_req), 0);

        // R1/R2: zero-run threshold and release through every channel
        for (int k = 0; k < CH_N; k++) begin
            send_zeros(511);
            wait_ref(10);
            check(mute_n == 1'b1, "R1", "511 zeros", int'(mute_n), 1);
            send_zeros(1);
            wait_ref(10);
            check(mute_n == 1'b0, "R1", "512 zeros", int'(mute_n), 0);
            send_zeros(40);
            wait_ref(10);
            check(mute_n == 1'b0, "R4", "saturated run", int'(mute_n), 0);
            d = '0;
            d[k*SMP_W + 4*k] = 1'b1;
            send(d);
            wait_ref(10);
            check(mute_n == 1'b1, "R2", $sformatf("release ch%0d", k), int'(mute_n), 1);
        end

        // R3: disabled auto-mute, then a fresh run after re-enable
        @(negedge mclk) auto_mute_en = 1'b0;
        send_zeros(600);
        wait_ref(10);
        check(mute_n == 1'b1, "R3", "disabled no mute", int'(mute_n), 1);
        @(negedge mclk) auto_mute_en = 1'b1;
        send_zeros(300);
        wait_ref(10);
        check(mute_n == 1'b1, "R3", "fresh count", int'(mute_n), 1);
        send_zeros(212);
        wait_ref(10);
        check(mute_n == 1'b0, "R3", "full fresh run", int'(mute_n), 0);
        send(DW'(2));
        wait_ref(10);

        // R5: forced mute
        @(negedge ref_clk) force_mute = 1'b1;
        wait_ref(2);
        check(mute_n == 1'b0, "R5", "forced", int'(mute_n), 0);
        @(negedge ref_clk) force_mute = 1'b0;
        wait_ref(2);
        check(mute_n == 1'b1, "R5", "unforced", int'(mute_n), 1);

        // R6: power-down
        @(negedge ref_clk) power_down = 1'b1;
        wait_ref(2);
        check(mute_n == 1'b0, "R6", "power down", int'(mute_n), 0);
        @(negedge ref_clk) power_down = 1'b0;
        wait_ref(2);
        check(mute_n == 1'b1, "R6", "power up", int'(mute_n), 1);

        // R7: drift of exactly 32 is tolerated
        rs_cnt = 0;
        next_per = 96;
        wait_frames(1);
        next_per = 64;
        wait_frames(4);
        wait_ref(20);
        check(rs_cnt == 0, "R7", "drift 32 resyncs", rs_cnt, 0);
        check(clk_err == 1'b0, "R8", "drift 32 err", int'(clk_err), 0);

        // R7/R8: drift of 33 each way
        next_per = 97;
        wait_frames(1);
        next_per = 64;
        wait_frames(1);
        wait_ref(20);
        check(clk_err == 1'b1, "R8", "err after drift 33", int'(clk_err), 1);
        check(mute_n == 1'b0, "R10", "mute on ratio err", int'(mute_n), 0);
        wait_frames(1);
        wait_ref(20);
        check(clk_err == 1'b1, "R8", "err held after one clean", int'(clk_err), 1);
        wait_frames(4);
        wait_ref(20);
        check(rs_cnt == 2, "R7", "drift 33 resyncs", rs_cnt, 2);
        check(clk_err == 1'b0, "R8", "err cleared", int'(clk_err), 0);
        check(mute_n == 1'b1, "R10", "mute released", int'(mute_n), 1);

        // R9: MCLK stop timeout and recovery
        mclk_run = 1'b0;
        wait_ref(1900);
        check(standby_req == 1'b0, "R9", "before timeout", int'(standby_req), 0);
        wait_ref(200);
        check(standby_req == 1'b1, "R9", "standby", int'(standby_req), 1);
        check(clk_err == 1'b1, "R9", "clk_err stopped", int'(clk_err), 1);
        check(mute_n == 1'b0, "R10", "mute stopped", int'(mute_n), 0);
        mclk_run = 1'b1;
        wait_ref(100);
        check(standby_req == 1'b0, "R9", "standby cleared", int'(standby_req), 0);
        check(clk_err == 1'b0, "R9", "clk_err cleared", int'(clk_err), 0);
        check(mute_n == 1'b1, "R9", "mute after resume", int'(mute_n), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule